// File: doc/BRIEF.md
# MSI Capability and Message Generator

This block sits on the device side of a PCI-style endpoint. It holds a message-signalled interrupt capability structure in configuration space and turns internal interrupt causes into posted memory writes. Software finds the structure by its capability ID. It programs the target address and the data word, grants a number of vectors, and sets the enable bit. From then on, every pending cause produces one write request on a valid/ready port.

When software grants more than one vector, the low bits of the programmed data word are replaced by the index of the cause. Each cause therefore reaches a different vector at the host. Causes are served lowest index first. A cause stays pending until its write is accepted. A build-time parameter selects 64-bit address capability. With that capability, an upper address register exists and the data register moves up one dword.

Top module: `msi_msg_gen`

## Requirements
- R1: Configuration dword 0 reads capability ID 0x05 in bits 7:0, the next pointer parameter (default 0x00) in bits 15:8, and the message control word in bits 31:16.
- R2: Message control bit 0 is the writable enable and bits 6:4 are the writable granted-count exponent; both reset to 0. Bits 3:1 are read-only and hold log2 of the cause count. Bit 7 is read-only and is 1 when 64-bit addressing is built in. All other bits read 0, and writes to read-only bits have no effect.
- R3: Dword 1 holds the lower message address, with bits 1:0 reading 0. With 64-bit capability, dword 2 holds the upper address and dword 3 holds the data in bits 15:0. Without it, dword 2 holds the data and dword 3 reads 0. Data bits 31:16 always read 0.
- R4: While the enable bit is clear, no write request is raised. Causes that arrive meanwhile stay pending and are issued once the enable bit is set.
- R5: The write address is {upper, lower} with 64-bit capability and {32'h0, lower} without it.
- R6: The write data is {16'h0, D}. D equals the programmed data with its low g bits replaced by the low g bits of the cause index. g is the granted exponent, clamped to the requested exponent.
- R7: Pending causes are issued lowest index first, one write per accepted handshake. While valid is high and ready is low, address and data hold steady. A cause is cleared only when its write is accepted.
- R8: Repeated requests from a cause that is still pending merge into a single write.
- R9: After reset no write request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 2 | Dword index within the capability |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| cause_req | input | NUM_CAUSES | One-cycle pulses raising interrupt causes |
| m_valid | output | 1 | Memory-write request valid |
| m_ready | input | 1 | Memory-write request accepted |
| m_addr | output | 64 | Write address |
| m_data | output | 32 | Write data |

## Verification
The assertions rely on a few properties of the inputs. A write is accepted only in a cycle where valid and ready are both high. Configuration writes occur only under cfg_we. The stability property also assumes the receiver never withdraws a request that the block is still presenting. The stimulus keeps within these limits: it drives inputs away from the clock edge, it holds ready low across bursts to exercise back-pressure, and it issues each new pulse for a cause only once that cause's previous write has been accepted or is still in flight.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [7:0] MSI_CAP_ID = 8'h05;

  // Number of substituted data bits: granted exponent clamped to requested.
  function automatic logic [2:0] eff_bits(input logic [2:0] granted,
                                          input logic [2:0] requested);
    return (granted > requested) ? requested : granted;
  endfunction

  // Replace the low 'nbits' bits of the programmed data with the cause index.
  function automatic logic [15:0] compose_data(input logic [15:0] base,
                                               input logic [4:0]  idx,
                                               input logic [2:0]  nbits);
    logic [15:0] mask;
    mask = (16'd1 << nbits) - 16'd1;
    return (base & ~mask) | ({11'd0, idx} & mask);
  endfunction

  // Index of the lowest set bit (0 when none is set).
  function automatic logic [4:0] lowest_index(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00,
  parameter int         REQ_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_addr,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        msi_en,
  output logic [2:0]  granted,
  output logic [31:0] addr_lo,
  output logic [31:0] addr_hi,
  output logic [15:0] msg_data
);
  localparam logic [1:0] DW_CTRL = 2'd0;
  localparam logic [1:0] DW_ALO  = 2'd1;
  localparam logic [1:0] DW_AHI  = 2'd2;
  localparam logic [1:0] DW_DATA = ADDR64 ? 2'd3 : 2'd2;

  logic [29:0] alo_q;
  logic [15:0] ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_en   <= 1'b0;
      granted  <= 3'd0;
      alo_q    <= '0;
      msg_data <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == DW_CTRL) begin
        msi_en  <= cfg_wdata[16];
        granted <= cfg_wdata[22:20];
      end
      if (cfg_addr == DW_ALO)  alo_q    <= cfg_wdata[31:2];
      if (cfg_addr == DW_DATA) msg_data <= cfg_wdata[15:0];
    end
  end

  generate
    if (ADDR64) begin : g_hi
      logic [31:0] ahi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ahi_q <= '0;
        else if (cfg_we && cfg_addr == DW_AHI) ahi_q <= cfg_wdata;
      end
      assign addr_hi = ahi_q;
    end else begin : g_nohi
      assign addr_hi = 32'h0;
    end
  endgenerate

  assign addr_lo   = {alo_q, 2'b00};
  assign ctrl_word = {8'h00, ADDR64, granted, 3'(REQ_LOG2), msi_en};

  always_comb begin
    cfg_rdata = 32'h0;
    if (cfg_addr == DW_CTRL)               cfg_rdata = {ctrl_word, NEXT_PTR, MSI_CAP_ID};
    else if (cfg_addr == DW_ALO)           cfg_rdata = addr_lo;
    else if (cfg_addr == DW_DATA)          cfg_rdata = {16'h0, msg_data};
    else if (ADDR64 && cfg_addr == DW_AHI) cfg_rdata = addr_hi;
  end

  // R2
  granted_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> ($stable(granted) && $stable(msi_en)));
endmodule

// File: rtl/msi_pending_arb.sv
module msi_pending_arb
  import msi_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     raise,
  input  logic             hold_valid,
  input  logic [IDX_W-1:0] hold_idx,
  input  logic             accept,
  output logic [N-1:0]     pend_q,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] hold_mask;
  logic [N-1:0] clr_mask;
  logic [N-1:0] cand;

  assign hold_mask = hold_valid ? (ONE << hold_idx) : '0;
  assign clr_mask  = accept ? hold_mask : '0;
  assign cand      = pend_q & ~hold_mask;
  assign pick_valid = |cand;
  assign pick_idx   = IDX_W'(lowest_index(32'(cand)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | raise;
  end

  // R7
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0($past(pend_q) & ~pend_q));
  // R7
  clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_q) & ~pend_q)) |-> $past(accept));
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_pkg::*;
#(
  parameter int         NUM_CAUSES = 8,
  parameter bit         ADDR64     = 1'b1,
  parameter logic [7:0] NEXT_PTR   = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_addr,
  input  logic                  cfg_we,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic [NUM_CAUSES-1:0] cause_req,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [63:0]           m_addr,
  output logic [31:0]           m_data
);
  localparam int IDX_W    = $clog2(NUM_CAUSES);
  localparam int REQ_LOG2 = IDX_W;

  logic        msi_en;
  logic [2:0]  granted;
  logic [31:0] addr_lo, addr_hi;
  logic [15:0] msg_data;

  logic [NUM_CAUSES-1:0] pend_q;
  logic                  pick_valid;
  logic [IDX_W-1:0]      pick_idx;

  logic             out_valid;
  logic [IDX_W-1:0] out_idx;
  logic [63:0]      out_addr;
  logic [31:0]      out_data;
  logic             handshake;
  logic             load;

  msi_cfg_regs #(.ADDR64(ADDR64), .NEXT_PTR(NEXT_PTR), .REQ_LOG2(REQ_LOG2)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msi_en(msi_en),
    .granted(granted), .addr_lo(addr_lo), .addr_hi(addr_hi), .msg_data(msg_data)
  );

  msi_pending_arb #(.N(NUM_CAUSES)) u_arb (
    .clk(clk), .rst_n(rst_n), .raise(cause_req), .hold_valid(out_valid),
    .hold_idx(out_idx), .accept(handshake), .pend_q(pend_q),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  assign handshake = out_valid && m_ready;
  assign load      = pick_valid && msi_en && (!out_valid || handshake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_idx   <= pick_idx;
      out_addr  <= ADDR64 ? {addr_hi, addr_lo} : {32'h0, addr_lo};
      out_data  <= {16'h0, compose_data(msg_data, 5'(pick_idx),
                                        eff_bits(granted, 3'(REQ_LOG2)))};
    end else if (handshake) begin
      out_valid <= 1'b0;
    end
  end

  assign m_valid = out_valid;
  assign m_addr  = out_addr;
  assign m_data  = out_data;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data)));
  // R4
  issue_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(msi_en));
  // R7
  inflight_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> pend_q[out_idx]);
  // R5
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_addr[1:0] == 2'b00));
endmodule

// File: tb/test_msi_msg_gen.sv
module test_msi_msg_gen;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NC-1:0] cause_req = '0;
  logic        m_valid, m_ready = 1'b1;
  logic [63:0] m_addr;
  logic [31:0] m_data;

  logic [1:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic [NC-1:0] b_cause = '0;
  logic        b_valid;
  logic [63:0] b_maddr;
  logic [31:0] b_mdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  msi_msg_gen #(.NUM_CAUSES(NC), .ADDR64(1'b1)) i_msi_msg_gen (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cause_req(cause_req),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data));

  msi_msg_gen #(.NUM_CAUSES(NC), .ADDR64(1'b0)) i_msi_msg_gen_a32 (
    .clk(clk), .rst_n(rst_n), .cfg_addr(b_addr), .cfg_we(b_we),
    .cfg_wdata(b_wdata), .cfg_rdata(b_rdata), .cause_req(b_cause),
    .m_valid(b_valid), .m_ready(1'b1), .m_addr(b_maddr), .m_data(b_mdata));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected data built by shifting instead of masking.
  function automatic logic [31:0] exp_data(input logic [15:0] base, input int idx, input int g);
    int gg;
    logic [15:0] hi;
    gg = (g > 3) ? 3 : g;
    hi = (base >> gg) << gg;
    return {16'h0, hi | 16'(idx % (1 << gg))};
  endfunction

  task automatic push(input logic [63:0] a, input logic [31:0] d, input string tag);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  // Monitor: one compare per handshake.
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (q_data.size() == 0) begin
        check("R7 unexpected write", {m_addr[31:0], m_data}, 64'h0);
      end else begin
        string t;
        logic [63:0] ea;
        logic [31:0] ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        t  = q_tag.pop_front();
        check({t, " addr"}, m_addr, ea);
        check({t, " data"}, {32'h0, m_data}, {32'h0, ed});
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic b_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    b_addr = a; b_wdata = d; b_we = 1'b1;
    @(negedge clk);
    b_we = 1'b0;
  endtask

  task automatic b_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    b_addr = a;
    #1 d = b_rdata;
  endtask

  task automatic pulse(input logic [NC-1:0] m);
    @(negedge clk);
    cause_req = m;
    @(negedge clk);
    cause_req = '0;
  endtask

  task automatic drain;
    for (int i = 0; i < 100 && q_data.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 queue drained", 64'(q_data.size()), 64'd0);
  endtask

  localparam logic [63:0] A64 = 64'h0000_0001_FEE0_100C;
  localparam logic [15:0] BASE = 16'h4A37;

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 no request after reset", {63'h0, m_valid}, 64'h0);
    cfg_read(2'd0, rd);
    check("R1 R2 header after reset", {32'h0, rd}, 64'h0086_0005);

    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_read(2'd0, rd);
    check("R2 read-only fields kept", {32'h0, rd}, 64'h00F7_0005);
    cfg_write(2'd0, 32'h0);

    cfg_write(2'd1, 32'hFEE0_100F);
    cfg_write(2'd2, 32'h0000_0001);
    cfg_write(2'd3, 32'hFFFF_4A37);
    cfg_read(2'd1, rd);
    check("R3 lower address", {32'h0, rd}, 64'hFEE0_100C);
    cfg_read(2'd2, rd);
    check("R3 upper address", {32'h0, rd}, 64'h1);
    cfg_read(2'd3, rd);
    check("R3 data register", {32'h0, rd}, 64'h4A37);

    // R4: causes while disabled stay pending
    cfg_write(2'd0, 32'h0030_0000);
    pulse(8'b0010_0100);
    repeat (10) @(negedge clk);
    check("R4 no request while disabled", {63'h0, m_valid}, 64'h0);
    push(A64, exp_data(BASE, 2, 3), "R4 R6 cause2");
    push(A64, exp_data(BASE, 5, 3), "R4 R6 cause5");
    cfg_write(2'd0, 32'h0031_0000);
    drain();

    // R6: fold with two vectors
    cfg_write(2'd0, 32'h0011_0000);
    push(A64, exp_data(BASE, 6, 1), "R6 fold cause6");
    pulse(8'b0100_0000);
    drain();
    push(A64, exp_data(BASE, 7, 1), "R6 fold cause7");
    pulse(8'b1000_0000);
    drain();

    // R6: single vector leaves data unchanged
    cfg_write(2'd0, 32'h0001_0000);
    push(A64, {16'h0, BASE}, "R6 single vector");
    pulse(8'b0001_0000);
    drain();

    // R6: granted above requested is clamped
    cfg_write(2'd0, 32'h0071_0000);
    push(A64, exp_data(BASE, 1, 7), "R6 clamp");
    pulse(8'b0000_0010);
    drain();

    // R7 R8: burst under back-pressure
    cfg_write(2'd0, 32'h0031_0000);
    @(negedge clk);
    m_ready = 1'b0;
    for (int i = 0; i < NC; i++) push(A64, exp_data(BASE, i, 3), "R7 priority order");
    pulse(8'hFF);
    repeat (3) @(negedge clk);
    held = m_data;
    pulse(8'h01);
    repeat (3) @(negedge clk);
    check("R7 request held", {63'h0, m_valid}, 64'h1);
    check("R7 data stable", {32'h0, m_data}, {32'h0, held});
    m_ready = 1'b1;
    drain();
    check("R8 merged request, no extra write", {63'h0, m_valid}, 64'h0);

    // R2 R3 R5: instance without 64-bit capability
    b_read(2'd0, rd);
    check("R2 32-bit control", {32'h0, rd}, 64'h0006_0005);
    b_write(2'd1, 32'hFEE0_2000);
    b_write(2'd2, 32'hABCD_1234);
    b_read(2'd2, rd);
    check("R3 32-bit data register", {32'h0, rd}, 64'h1234);
    b_read(2'd3, rd);
    check("R3 32-bit dword3 reads 0", {32'h0, rd}, 64'h0);
    b_write(2'd0, 32'h0031_0000);
    @(negedge clk);
    b_cause = 8'b0000_1000;
    @(negedge clk);
    b_cause = '0;
    for (int i = 0; i < 20 && !b_valid; i++) @(negedge clk);
    check("R5 32-bit address", b_maddr, 64'h0000_0000_FEE0_2000);
    check("R6 32-bit data", {32'h0, b_mdata}, {32'h0, exp_data(16'h1234, 3, 3)});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule